// File: doc/BRIEF.md
# Memory-Region Coprocessor Scoreboard

This block sits between a processor and a reconfigurable array that performs memory-to-memory operations. The processor hands over an operation as a function number, a source base address, a destination base address and a log2 block size; the block records it in a small table of in-flight operations and returns a tag. While array operations run, the processor keeps executing. Every processor load and store address is compared against the recorded regions, and an access that could observe or disturb an unfinished operation is stalled, so memory looks as if each operation happened at its place in program order.

Operations leave the table toward the array units in the order they were issued. The oldest waiting operation is dispatched only when its function is loaded into one of a few context slots and its regions do not collide with any earlier operation that is still running on a unit. A missing function triggers a configuration load into a free slot or, failing that, the least recently used slot. A unit returns the tag when it finishes, which frees the entry.

Top module: `region_scoreboard`

## Requirements
- R1: After a synchronous active-high reset the table is empty and every context slot is invalid: `iss_busy`, `ld_stall`, `st_stall`, `disp_valid` and `cfg_req` are all 0.
- R2: An issue is accepted when `iss_valid` is high and `iss_busy` is low; `iss_tag` names the lowest-numbered free entry. With all 4 entries occupied `iss_busy` is 1 and an issue attempt leaves the table unchanged.
- R3: `ld_stall` is 1 exactly when `ld_valid` is 1 and `ld_addr` lies in the destination region of an occupied entry; a region covers every address equal to the base once the low `lg` bits of both are ignored.
- R4: `st_stall` is 1 exactly when `st_valid` is 1 and `st_addr` lies in the source or the destination region of an occupied entry.
- R5: A `done_valid` pulse with the tag of a dispatched entry frees it on the next clock edge: its regions stop causing stalls and its tag can be issued again.
- R6: When the oldest undispatched operation needs a function that is not resident, `cfg_req` rises with `cfg_func` and `cfg_slot` held steady until a `cfg_done` pulse; that operation is not dispatched before the slot becomes valid.
- R7: The slot chosen for a load is the lowest-numbered invalid slot, otherwise the slot least recently used by a load or a dispatch; no function is resident in two slots.
- R8: Operations are dispatched strictly in issue order. The oldest one waits while its source overlaps the destination of a running operation, or its destination overlaps the source or destination of a running operation, and all later operations wait behind it.
- R9: `disp_valid` with `disp_tag`, `disp_slot`, `disp_src`, `disp_dst` and `disp_lg` stays stable until `disp_ready` is high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | New operation offered |
| iss_func | input | FW | Function number of the new operation |
| iss_src | input | AW | Source base address |
| iss_dst | input | AW | Destination base address |
| iss_lg | input | LGW | log2 of the block size in address units |
| iss_busy | output | 1 | Table full, offered operation refused |
| iss_tag | output | TW | Tag given to an accepted operation |
| ld_valid | input | 1 | Processor load present |
| ld_addr | input | AW | Processor load address |
| ld_stall | output | 1 | Load must wait |
| st_valid | input | 1 | Processor store present |
| st_addr | input | AW | Processor store address |
| st_stall | output | 1 | Store must wait |
| disp_valid | output | 1 | Oldest operation ready for a unit |
| disp_ready | input | 1 | A unit takes the offered operation |
| disp_tag | output | TW | Tag of the offered operation |
| disp_slot | output | SW | Context slot holding its function |
| disp_src | output | AW | Its source base |
| disp_dst | output | AW | Its destination base |
| disp_lg | output | LGW | Its log2 block size |
| done_valid | input | 1 | A unit has finished an operation |
| done_tag | input | TW | Tag of the finished operation |
| cfg_req | output | 1 | Context load requested |
| cfg_func | output | FW | Function to load |
| cfg_slot | output | SW | Slot to load it into |
| cfg_done | input | 1 | Pulse: requested load complete |

## Verification
The bench builds the block with a 10-bit address and a 3-bit size field, so regions span up to 128 addresses and random load and store addresses fall inside recorded regions often enough to exercise both stall outcomes. Four table entries and four context slots with fourteen function numbers keep the table full within a few issues and force frequent slot replacement, so the free-slot and least-recently-used choices are compared against an independent recency model over many operations.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
    typedef enum logic {
        CFG_IDLE = 1'b0,
        CFG_LOAD = 1'b1
    } cfg_st_e;
endpackage

// File: rtl/rsb_region_hit.sv
// Power-of-two region membership: addr is inside the region when it
// matches base on every bit above the lg lowest ones.
module rsb_region_hit #(
    parameter int AW  = 32,
    parameter int LGW = 5
) (
    input  logic [AW-1:0]  addr,
    input  logic [AW-1:0]  base,
    input  logic [LGW-1:0] lg,
    output logic           hit
);
    logic [AW-1:0] keep;

    assign keep = ~((AW'(1) << lg) - AW'(1));
    assign hit  = ((addr ^ base) & keep) == '0;
endmodule

// File: rtl/rsb_ctx_cache.sv
// Resident function contexts with least-recently-used replacement.
module rsb_ctx_cache
    import rsb_pkg::*;
#(
    parameter int FW    = 4,
    parameter int NSLOT = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     look_valid,
    input  logic [FW-1:0]            look_func,
    input  logic                     touch,
    input  logic                     cfg_done,
    output logic                     hit,
    output logic [$clog2(NSLOT)-1:0] hit_slot,
    output logic                     cfg_req,
    output logic [FW-1:0]            cfg_func,
    output logic [$clog2(NSLOT)-1:0] cfg_slot
);
    localparam int SW = $clog2(NSLOT);

    typedef struct packed {
        logic [NSLOT-1:0]         vld;
        logic [NSLOT-1:0][FW-1:0] fn;
        logic [NSLOT-1:0][SW-1:0] age;
        cfg_st_e                  st;
        logic [SW-1:0]            slot;
    } ctx_t;

    ctx_t s_d, s_q;
    logic [NSLOT-1:0] hitv;
    logic [SW-1:0]    victim;
    logic [SW-1:0]    tslot;
    logic             tdo;
    logic             found;

    for (genvar i = 0; i < NSLOT; i++) begin : g_hit
        assign hitv[i] = s_q.vld[i] && (s_q.fn[i] == look_func);
    end

    always_comb begin
        hit_slot = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (hitv[i]) hit_slot = SW'(i);
        end
        victim = '0;
        found  = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (!s_q.vld[i] && !found) begin
                victim = SW'(i);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (s_q.age[i] == SW'(NSLOT - 1)) victim = SW'(i);
            end
        end
    end

    assign hit = |hitv;

    always_comb begin
        s_d   = s_q;
        tdo   = 1'b0;
        tslot = hit_slot;
        case (s_q.st)
            CFG_IDLE: begin
                if (look_valid && !hit) begin
                    s_d.st          = CFG_LOAD;
                    s_d.slot        = victim;
                    s_d.fn[victim]  = look_func;
                    s_d.vld[victim] = 1'b0;
                    tdo             = 1'b1;
                    tslot           = victim;
                end else if (touch) begin
                    tdo = 1'b1;
                end
            end
            default: begin
                if (cfg_done) begin
                    s_d.vld[s_q.slot] = 1'b1;
                    s_d.st            = CFG_IDLE;
                end
            end
        endcase
        if (tdo) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (SW'(i) == tslot) s_d.age[i] = '0;
                else if (s_q.age[i] < s_q.age[tslot]) s_d.age[i] = s_q.age[i] + SW'(1);
            end
        end
        if (rst) begin
            s_d.vld  = '0;
            s_d.fn   = '0;
            s_d.st   = CFG_IDLE;
            s_d.slot = '0;
            for (int i = 0; i < NSLOT; i++) s_d.age[i] = SW'(i);
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign cfg_req  = (s_q.st == CFG_LOAD);
    assign cfg_func = s_q.fn[s_q.slot];
    assign cfg_slot = s_q.slot;

    // R7: a function is never resident in two slots
    p_ctx_unique_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hitv));

    // R6: an open load request keeps its slot and function until completion
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_req && !cfg_done |=> cfg_req && $stable(cfg_slot) && $stable(cfg_func));
endmodule

// File: rtl/region_scoreboard.sv
module region_scoreboard #(
    parameter int AW    = 32,
    parameter int LGW   = 5,
    parameter int FW    = 4,
    parameter int NENT  = 4,
    parameter int NSLOT = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     iss_valid,
    input  logic [FW-1:0]            iss_func,
    input  logic [AW-1:0]            iss_src,
    input  logic [AW-1:0]            iss_dst,
    input  logic [LGW-1:0]           iss_lg,
    output logic                     iss_busy,
    output logic [$clog2(NENT)-1:0]  iss_tag,
    input  logic                     ld_valid,
    input  logic [AW-1:0]            ld_addr,
    output logic                     ld_stall,
    input  logic                     st_valid,
    input  logic [AW-1:0]            st_addr,
    output logic                     st_stall,
    output logic                     disp_valid,
    input  logic                     disp_ready,
    output logic [$clog2(NENT)-1:0]  disp_tag,
    output logic [$clog2(NSLOT)-1:0] disp_slot,
    output logic [AW-1:0]            disp_src,
    output logic [AW-1:0]            disp_dst,
    output logic [LGW-1:0]           disp_lg,
    input  logic                     done_valid,
    input  logic [$clog2(NENT)-1:0]  done_tag,
    output logic                     cfg_req,
    output logic [FW-1:0]            cfg_func,
    output logic [$clog2(NSLOT)-1:0] cfg_slot,
    input  logic                     cfg_done
);
    localparam int TW = $clog2(NENT);
    localparam int SW = $clog2(NSLOT);
    localparam int CW = $clog2(NENT + 1);

    typedef struct packed {
        logic [NENT-1:0]          vld;
        logic [NENT-1:0]          dsp;
        logic [NENT-1:0][AW-1:0]  src;
        logic [NENT-1:0][AW-1:0]  dst;
        logic [NENT-1:0][LGW-1:0] lg;
        logic [NENT-1:0][FW-1:0]  fn;
        logic [NENT-1:0][TW-1:0]  q;
        logic [CW-1:0]            qn;
    } tbl_t;

    tbl_t t_d, t_q;

    logic [TW-1:0]   hd;
    logic            head_ok;
    logic [NENT-1:0] blk, ldh, sth;
    logic            ctx_hit;
    logic [SW-1:0]   ctx_slot;
    logic            fire, acc;
    logic [TW-1:0]   free_tag;
    logic [CW-1:0]   q_wr;

    assign hd      = t_q.q[0];
    assign head_ok = (t_q.qn != '0);

    for (genvar j = 0; j < NENT; j++) begin : g_ent
        logic [LGW-1:0] lgm;
        logic rd_d, wr_d, wr_s, ld_d, st_s, st_d;
        assign lgm = (t_q.lg[hd] > t_q.lg[j]) ? t_q.lg[hd] : t_q.lg[j];
        rsb_region_hit #(.AW(AW), .LGW(LGW)) u_rd_d (.addr(t_q.src[hd]), .base(t_q.dst[j]), .lg(lgm), .hit(rd_d));
        rsb_region_hit #(.AW(AW), .LGW(LGW)) u_wr_d (.addr(t_q.dst[hd]), .base(t_q.dst[j]), .lg(lgm), .hit(wr_d));
        rsb_region_hit #(.AW(AW), .LGW(LGW)) u_wr_s (.addr(t_q.dst[hd]), .base(t_q.src[j]), .lg(lgm), .hit(wr_s));
        rsb_region_hit #(.AW(AW), .LGW(LGW)) u_ld_d (.addr(ld_addr), .base(t_q.dst[j]), .lg(t_q.lg[j]), .hit(ld_d));
        rsb_region_hit #(.AW(AW), .LGW(LGW)) u_st_s (.addr(st_addr), .base(t_q.src[j]), .lg(t_q.lg[j]), .hit(st_s));
        rsb_region_hit #(.AW(AW), .LGW(LGW)) u_st_d (.addr(st_addr), .base(t_q.dst[j]), .lg(t_q.lg[j]), .hit(st_d));
        assign blk[j] = t_q.vld[j] && t_q.dsp[j] && (rd_d || wr_d || wr_s);
        assign ldh[j] = t_q.vld[j] && ld_d;
        assign sth[j] = t_q.vld[j] && (st_s || st_d);
    end

    rsb_ctx_cache #(.FW(FW), .NSLOT(NSLOT)) u_ctx (
        .clk        (clk),
        .rst        (rst),
        .look_valid (head_ok),
        .look_func  (t_q.fn[hd]),
        .touch      (fire),
        .cfg_done   (cfg_done),
        .hit        (ctx_hit),
        .hit_slot   (ctx_slot),
        .cfg_req    (cfg_req),
        .cfg_func   (cfg_func),
        .cfg_slot   (cfg_slot)
    );

    assign ld_stall   = ld_valid && (|ldh);
    assign st_stall   = st_valid && (|sth);
    assign disp_valid = head_ok && ctx_hit && !(|blk);
    assign disp_tag   = hd;
    assign disp_slot  = ctx_slot;
    assign disp_src   = t_q.src[hd];
    assign disp_dst   = t_q.dst[hd];
    assign disp_lg    = t_q.lg[hd];
    assign fire       = disp_valid && disp_ready;
    assign iss_busy   = &t_q.vld;
    assign acc        = iss_valid && !iss_busy;
    assign iss_tag    = free_tag;

    always_comb begin
        free_tag = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (!t_q.vld[i]) free_tag = TW'(i);
        end
    end

    always_comb begin
        t_d  = t_q;
        q_wr = t_q.qn - CW'(fire);
        if (done_valid && t_q.vld[done_tag] && t_q.dsp[done_tag]) begin
            t_d.vld[done_tag] = 1'b0;
            t_d.dsp[done_tag] = 1'b0;
        end
        if (fire) begin
            t_d.dsp[hd] = 1'b1;
            for (int k = 0; k < NENT - 1; k++) t_d.q[k] = t_q.q[k + 1];
        end
        if (acc) begin
            t_d.vld[free_tag] = 1'b1;
            t_d.dsp[free_tag] = 1'b0;
            t_d.src[free_tag] = iss_src;
            t_d.dst[free_tag] = iss_dst;
            t_d.lg[free_tag]  = iss_lg;
            t_d.fn[free_tag]  = iss_func;
            t_d.q[TW'(q_wr)]  = free_tag;
        end
        t_d.qn = t_q.qn + CW'(acc) - CW'(fire);
        if (rst) begin
            t_d.vld = '0;
            t_d.dsp = '0;
            t_d.qn  = '0;
        end
    end

    always_ff @(posedge clk) begin
        t_q <= t_d;
    end

    // R2: an accepted issue occupies the entry named by its tag
    p_tag_alloc_r2: assert property (@(posedge clk) disable iff (rst)
        acc |=> t_q.vld[$past(iss_tag)]);

    // R5: completion of a dispatched entry releases it
    p_free_r5: assert property (@(posedge clk) disable iff (rst)
        done_valid && t_q.vld[done_tag] && t_q.dsp[done_tag] |=> !t_q.vld[$past(done_tag)]);

    // R9: an offer not taken stays on the same operation
    p_disp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        disp_valid && !disp_ready |=> disp_valid && $stable(disp_tag) && $stable(disp_slot));

    // R6: nothing is dispatched while a context load is open
    p_no_disp_loading_r6: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> !cfg_req);
endmodule

// File: tb/tb_region_scoreboard.sv
`timescale 1ns/1ps
module tb_region_scoreboard;
    localparam int AW = 10, LGW = 3, FW = 4, NENT = 4, NSLOT = 4;
    localparam int TW = $clog2(NENT), SW = $clog2(NSLOT);

    logic clk = 1'b0, rst = 1'b1;
    logic iss_valid = 0; logic [FW-1:0] iss_func = 0;
    logic [AW-1:0] iss_src = 0, iss_dst = 0; logic [LGW-1:0] iss_lg = 0;
    logic iss_busy; logic [TW-1:0] iss_tag;
    logic ld_valid = 0, st_valid = 0; logic [AW-1:0] ld_addr = 0, st_addr = 0;
    logic ld_stall, st_stall;
    logic disp_valid, disp_ready = 0; logic [TW-1:0] disp_tag; logic [SW-1:0] disp_slot;
    logic [AW-1:0] disp_src, disp_dst; logic [LGW-1:0] disp_lg;
    logic done_valid = 0; logic [TW-1:0] done_tag = 0;
    logic cfg_req; logic [FW-1:0] cfg_func; logic [SW-1:0] cfg_slot; logic cfg_done = 0;

    int checks = 0, errors = 0;
    int mfn[NSLOT]; bit mv[NSLOT]; int mts[NSLOT]; int now = 0;
    logic [AW-1:0] rs[NENT], rd[NENT]; int rl[NENT];

    always #4 clk = ~clk;

    region_scoreboard #(.AW(AW), .LGW(LGW), .FW(FW), .NENT(NENT), .NSLOT(NSLOT)) dut (.*);

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit inreg(logic [AW-1:0] a, logic [AW-1:0] b, int lg);
        return ((a ^ b) >> lg) == 0;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1; iss_valid = 0; disp_ready = 0; done_valid = 0; cfg_done = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        for (int i = 0; i < NSLOT; i++) begin mv[i] = 0; mts[i] = 0; end
    endtask

    task automatic issue(int f, logic [AW-1:0] s, logic [AW-1:0] d, int lg, int tag_exp, string req);
        @(negedge clk);
        iss_valid = 1; iss_func = FW'(f); iss_src = s; iss_dst = d; iss_lg = LGW'(lg);
        #1 if (tag_exp >= 0) check(req, "iss_tag", 32'(iss_tag), 32'(tag_exp));
        @(negedge clk); iss_valid = 0;
    endtask

    task automatic probe(logic [AW-1:0] la, logic [AW-1:0] sa);
        ld_valid = 1; st_valid = 1; ld_addr = la; st_addr = sa; #1;
    endtask

    task automatic finish_tag(int t);
        done_valid = 1; done_tag = TW'(t); @(negedge clk); done_valid = 0;
    endtask

    // One operation on an empty table, checked against a recency model (R6, R7)
    task automatic run_op(int f, logic [AW-1:0] s, logic [AW-1:0] d, int lg);
        int es = -1; bit emiss = 1; bit saw = 0; bit got = 0; int best;
        for (int i = 0; i < NSLOT; i++) if (mv[i] && mfn[i] == f) begin es = i; emiss = 0; end
        if (emiss) begin
            for (int i = NSLOT - 1; i >= 0; i--) if (!mv[i]) es = i;
            if (es < 0) begin
                best = 1 << 30;
                for (int i = 0; i < NSLOT; i++) if (mts[i] < best) begin best = mts[i]; es = i; end
            end
        end
        issue(f, s, d, lg, 0, "R2");
        for (int k = 0; k < 12 && !got; k++) begin
            #1;
            if (cfg_req && !saw) begin
                saw = 1;
                check("R7", "cfg_slot", 32'(cfg_slot), 32'(es));
                check("R6", "cfg_func", 32'(cfg_func), 32'(f));
                cfg_done = 1; @(negedge clk); cfg_done = 0;
            end else if (disp_valid) begin
                got = 1;
                check("R7", "disp_slot", 32'(disp_slot), 32'(es));
            end else @(negedge clk);
        end
        check("R6", "load needed", 32'(saw), 32'(emiss));
        check("R9", "dispatched", 32'(got), 32'd1);
        mv[es] = 1; mfn[es] = f; mts[es] = ++now;
        disp_ready = 1; @(negedge clk); disp_ready = 0;
        finish_tag(0);
    endtask

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd583));
        do_reset();
        // R1: reset state
        probe(10'h000, 10'h000);
        check("R1", "iss_busy", 32'(iss_busy), 0);
        check("R1", "ld_stall", 32'(ld_stall), 0);
        check("R1", "st_stall", 32'(st_stall), 0);
        check("R1", "disp_valid", 32'(disp_valid), 0);
        check("R1", "cfg_req", 32'(cfg_req), 0);

        // Op A: function 3 not resident, load into slot 0
        issue(3, 10'h100, 10'h200, 4, 0, "R2");
        @(negedge clk);
        probe(10'h205, 10'h105);
        check("R6", "cfg_req", 32'(cfg_req), 1);
        check("R6", "cfg_func", 32'(cfg_func), 3);
        check("R7", "cfg_slot", 32'(cfg_slot), 0);
        check("R3", "ld in dst", 32'(ld_stall), 1);
        check("R4", "st in src", 32'(st_stall), 1);
        probe(10'h105, 10'h20F);
        check("R3", "ld in src only", 32'(ld_stall), 0);
        check("R4", "st in dst", 32'(st_stall), 1);
        probe(10'h1FF, 10'h210);
        check("R4", "st outside", 32'(st_stall), 0);
        repeat (3) @(negedge clk);
        #1 check("R6", "cfg_req held", 32'(cfg_req), 1);
        check("R6", "no dispatch while loading", 32'(disp_valid), 0);
        cfg_done = 1; @(negedge clk); cfg_done = 0;
        #1 check("R6", "disp after load", 32'(disp_valid), 1);
        check("R9", "disp_tag", 32'(disp_tag), 0);
        check("R9", "disp_slot", 32'(disp_slot), 0);
        check("R9", "disp_src", 32'(disp_src), 32'h100);
        repeat (2) @(negedge clk);
        #1 check("R9", "offer held", 32'(disp_valid), 1);
        check("R9", "disp_dst held", 32'(disp_dst), 32'h200);
        disp_ready = 1; @(negedge clk); disp_ready = 0;
        #1 check("R9", "offer taken", 32'(disp_valid), 0);

        // B reads A's destination: blocked; C and D wait behind it
        issue(3, 10'h208, 10'h280, 3, 1, "R2");
        #1 check("R8", "read-after-write blocked", 32'(disp_valid), 0);
        issue(3, 10'h300, 10'h380, 3, 2, "R2");
        issue(3, 10'h040, 10'h180, 3, 3, "R2");
        #1 check("R8", "later ops wait", 32'(disp_valid), 0);
        check("R2", "busy when full", 32'(iss_busy), 1);
        issue(3, 10'h0C0, 10'h3C0, 2, -1, "R2");
        probe(10'h3C0, 10'h3C1);
        check("R2", "refused op no ld stall", 32'(ld_stall), 0);
        check("R2", "refused op no st stall", 32'(st_stall), 0);
        check("R2", "still busy", 32'(iss_busy), 1);
        probe(10'h385, 10'h043);
        check("R3", "ld in C dst", 32'(ld_stall), 1);
        check("R4", "st in D src", 32'(st_stall), 1);

        @(negedge clk); finish_tag(0);
        probe(10'h205, 10'h10A);
        check("R5", "busy cleared", 32'(iss_busy), 0);
        check("R5", "tag reusable", 32'(iss_tag), 0);
        check("R5", "ld stall cleared", 32'(ld_stall), 0);
        check("R5", "st stall cleared", 32'(st_stall), 0);
        check("R8", "B dispatchable", 32'(disp_valid), 1);
        check("R8", "B first", 32'(disp_tag), 1);
        disp_ready = 1;
        @(negedge clk); #1 check("R8", "C second", 32'(disp_tag), 2);
        @(negedge clk); #1 check("R8", "D third", 32'(disp_tag), 3);
        @(negedge clk); disp_ready = 0;
        #1 check("R8", "queue empty", 32'(disp_valid), 0);
        finish_tag(1); finish_tag(2); finish_tag(3);

        // Write-after-read: G2 writes over G1's source
        issue(3, 10'h100, 10'h200, 4, 0, "R2");
        #1 check("R9", "G1 offered", 32'(disp_valid), 1);
        disp_ready = 1; @(negedge clk); disp_ready = 0;
        issue(3, 10'h300, 10'h108, 3, 1, "R2");
        #1 check("R8", "write-after-read blocked", 32'(disp_valid), 0);
        finish_tag(0);
        #1 check("R8", "G2 released", 32'(disp_valid), 1);
        check("R8", "G2 tag", 32'(disp_tag), 1);
        disp_ready = 1; @(negedge clk); disp_ready = 0;
        finish_tag(1);

        // Context replacement: fill, reuse, evict, then random functions (R7)
        do_reset();
        run_op(1, 10'h000, 10'h100, 2);
        run_op(2, 10'h000, 10'h100, 2);
        run_op(3, 10'h000, 10'h100, 2);
        run_op(4, 10'h000, 10'h100, 2);
        run_op(1, 10'h000, 10'h100, 2);
        run_op(5, 10'h000, 10'h100, 2);
        for (int n = 0; n < 40; n++)
            run_op($urandom_range(13), AW'($urandom), AW'($urandom), $urandom_range(7));

        // Random regions against processor accesses (R3, R4)
        for (int r = 0; r < 4; r++) begin
            do_reset();
            for (int i = 0; i < NENT; i++) begin
                rs[i] = AW'($urandom); rd[i] = AW'($urandom); rl[i] = $urandom_range(6);
                issue(0, rs[i], rd[i], rl[i], i, "R2");
            end
            for (int n = 0; n < 40; n++) begin
                logic [AW-1:0] la, sa; bit el, es2; int e;
                e = $urandom_range(NENT - 1);
                la = ($urandom_range(1)) ? AW'($urandom) : (rd[e] ^ AW'($urandom_range(3)));
                e = $urandom_range(NENT - 1);
                sa = ($urandom_range(1)) ? AW'($urandom) : (rs[e] ^ AW'($urandom_range(3)));
                el = 0; es2 = 0;
                for (int i = 0; i < NENT; i++) begin
                    if (inreg(la, rd[i], rl[i])) el = 1;
                    if (inreg(sa, rd[i], rl[i]) || inreg(sa, rs[i], rl[i])) es2 = 1;
                end
                @(negedge clk); probe(la, sa);
                check("R3", "random ld", 32'(ld_stall), 32'(el));
                check("R4", "random st", 32'(st_stall), 32'(es2));
            end
            ld_valid = 0; st_valid = 0; #1;
            check("R3", "no load no stall", 32'(ld_stall), 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule